// File: doc/BRIEF.md
# Two-Source Edge-Triggered Interrupt Controller

This block is the interrupt front end of a small microcontroller core. It watches two external interrupt pins and one timer overflow pulse. It raises a one-cycle take strobe toward the core, together with a one-bit vector select. The core uses that select to pick the jump page; the handler entry sits at fixed offset 0x3F inside the page. Pin levels are resampled only on the core's instruction-cycle enable. A pin that produces an edge masks itself until software clears its mask. Both external pins feed a single shared input request latch. The timer has its own request latch.

A global enable flag decides whether a pending request is taken. Taking any interrupt clears the enable flag, and software sets it again with a strobe. A pending input request always goes ahead of a pending timer request. The timer request stays latched until its own turn comes. Software can read both mask flags and both synchronized pin levels. This lets the pins also serve as plain inputs, or as catch latches for short pulses. A pin pulse has to stay high, and stay low, for at least two instruction cycles to be seen reliably.

Top module: `irq_ctrl`

## Requirements
- R1: While reset is low, and at the first sample after it, irqTake, irqVec, intEnable, maskFlags and pinLevel are all 0.
- R2: Each pin passes through two sampling flops that advance only on clock edges where cycleEn is 1. pinLevel[i] shows the second flop. A level change therefore shows on pinLevel on the second cycleEn edge after it is applied.
- R3: An edge pulse is formed for pin i only on a cycleEn edge, and only when pinLevel[i] is 1 while the level previously sampled after it was 0. A pin held high yields one pulse only.
- R4: An edge pulse on a pin whose mask is 0 sets that mask (maskFlags[i] = 1) and sets the input request. An edge pulse on a pin whose mask is already 1 raises no request.
- R5: A 1 on clrMask[i] clears maskFlags[i] at the next edge. If an edge pulse for that pin occurs in the same cycle, the mask ends up set.
- R6: A 1 on timerOvf sets the timer request, which is held until served.
- R7: When intEnable is 1 and the input request is pending, the next edge makes irqTake 1 for one cycle with irqVec = 0 (input), clears the input request and clears intEnable.
- R8: While intEnable is 0, no interrupt is taken and pending requests stay held.
- R9: When both requests are pending, the input request is served first. The timer request stays pending and is later served with irqVec = 1 (timer).
- R10: setEnable sets intEnable at the next edge, unless an interrupt is taken on that edge; in that case intEnable becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cycleEn | input | 1 | Instruction-cycle sampling enable |
| pinIn | input | 2 | Raw external interrupt pin levels |
| timerOvf | input | 1 | One-cycle timer overflow request |
| setEnable | input | 1 | Software strobe that sets the interrupt enable |
| clrMask | input | 2 | Software strobes that clear the per-pin masks |
| irqTake | output | 1 | One-cycle strobe: core must take an interrupt |
| irqVec | output | 1 | Vector select valid with irqTake: 0 input, 1 timer |
| intEnable | output | 1 | Current global interrupt enable |
| maskFlags | output | 2 | Per-pin mask flags for program reads |
| pinLevel | output | 2 | Synchronized pin levels for program reads |

## Verification
Directed runs hold a pin high for many cycles and confirm that only one take results. They then re-pulse a pin while its mask is set and confirm that nothing is taken. Next they post a timer overflow and a pin edge together while disabled, then enable twice. The two take strobes must come out input first, then timer. Random runs vary cycleEn gaps, pin toggles, overflow pulses, mask clears and enable strobes. They are compared each cycle against a bench reference. This separates errors in sampling cadence (pinLevel timing) from errors in masking (maskFlags) and from errors in arbitration or enable handling (irqTake, irqVec, intEnable).

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_PINS = 2;
  localparam int SYNC_STAGES = 2;

  localparam logic VEC_INPUT = 1'b0;
  localparam logic VEC_TIMER = 1'b1;

  // strobes from control to datapath
  typedef struct packed {
    logic clrInReq;
    logic clrTmReq;
  } reqClr_t;
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int PINS = NUM_PINS,
  parameter int STAGES = SYNC_STAGES
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cycleEn,
  input  logic [PINS-1:0] pinIn,
  input  logic            timerOvf,
  input  logic [PINS-1:0] clrMask,
  input  reqClr_t         strobes,
  output logic            inReq,
  output logic            tmReq,
  output logic [PINS-1:0] maskFlags,
  output logic [PINS-1:0] pinLevel
);
  localparam int LAST = STAGES - 1;

  logic [PINS-1:0] syncQ [STAGES];
  logic [PINS-1:0] prevQ;
  logic [PINS-1:0] pulse;
  logic [PINS-1:0] accepted;
  logic [PINS-1:0] maskQ;
  logic            inReqQ;
  logic            tmReqQ;

  // sampling chain, advanced on the instruction-cycle enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ[0] <= '0;
    end else if (cycleEn) begin
      syncQ[0] <= pinIn;
    end
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncQ[s] <= '0;
        end else if (cycleEn) begin
          syncQ[s] <= syncQ[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ <= '0;
    end else if (cycleEn) begin
      prevQ <= syncQ[LAST];
    end
  end

  assign pulse    = {PINS{cycleEn}} & syncQ[LAST] & ~prevQ;
  assign accepted = pulse & ~maskQ;

  generate
    for (genvar g = 0; g < PINS; g++) begin : gMask
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          maskQ[g] <= 1'b0;
        end else if (pulse[g]) begin
          maskQ[g] <= 1'b1;
        end else if (clrMask[g]) begin
          maskQ[g] <= 1'b0;
        end
      end

      // R4
      edge_sets_req_chk: assert property (@(posedge clk) disable iff (!rstN)
        (pulse[g] && !maskQ[g]) |=> (maskQ[g] && inReqQ));

      // R5
      mask_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
        (clrMask[g] && !pulse[g]) |=> !maskQ[g]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inReqQ <= 1'b0;
      tmReqQ <= 1'b0;
    end else begin
      inReqQ <= (inReqQ & ~strobes.clrInReq) | (|accepted);
      tmReqQ <= (tmReqQ & ~strobes.clrTmReq) | timerOvf;
    end
  end

  // R6
  timer_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    timerOvf |=> tmReqQ);

  // R8
  in_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inReqQ && !strobes.clrInReq) |=> inReqQ);

  assign inReq     = inReqQ;
  assign tmReq     = tmReqQ;
  assign maskFlags = maskQ;
  assign pinLevel  = syncQ[LAST];
endmodule

// File: rtl/irq_control.sv
module irq_control
  import irq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inReq,
  input  logic    tmReq,
  input  logic    setEnable,
  output reqClr_t strobes,
  output logic    irqTake,
  output logic    irqVec,
  output logic    intEnable
);
  logic intEnQ;
  logic takeQ;
  logic vecQ;
  logic takeIn;
  logic takeTm;

  // input request always wins arbitration
  assign takeIn = intEnQ & inReq;
  assign takeTm = intEnQ & ~inReq & tmReq;

  assign strobes.clrInReq = takeIn;
  assign strobes.clrTmReq = takeTm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEnQ <= 1'b0;
      takeQ  <= 1'b0;
      vecQ   <= VEC_INPUT;
    end else begin
      takeQ <= takeIn | takeTm;
      vecQ  <= takeTm ? VEC_TIMER : VEC_INPUT;
      if (takeIn || takeTm) begin
        intEnQ <= 1'b0;
      end else if (setEnable) begin
        intEnQ <= 1'b1;
      end
    end
  end

  // R7
  in_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intEnQ && inReq) |=> (takeQ && vecQ == VEC_INPUT && !intEnQ));

  // R9
  tmr_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intEnQ && inReq && tmReq) |=> tmReq);

  // R8
  no_take_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !intEnQ |=> !takeQ);

  // R10
  enable_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (setEnable && !(intEnQ && (inReq || tmReq))) |=> intEnQ);

  assign irqTake   = takeQ;
  assign irqVec    = vecQ;
  assign intEnable = intEnQ;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cycleEn,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                timerOvf,
  input  logic                setEnable,
  input  logic [NUM_PINS-1:0] clrMask,
  output logic                irqTake,
  output logic                irqVec,
  output logic                intEnable,
  output logic [NUM_PINS-1:0] maskFlags,
  output logic [NUM_PINS-1:0] pinLevel
);
  reqClr_t strobes;
  logic    inReq;
  logic    tmReq;

  irq_datapath #(.PINS(NUM_PINS), .STAGES(SYNC_STAGES)) uData (
    .clk(clk), .rstN(rstN), .cycleEn(cycleEn), .pinIn(pinIn),
    .timerOvf(timerOvf), .clrMask(clrMask), .strobes(strobes),
    .inReq(inReq), .tmReq(tmReq), .maskFlags(maskFlags), .pinLevel(pinLevel)
  );

  irq_control uCtrl (
    .clk(clk), .rstN(rstN), .inReq(inReq), .tmReq(tmReq),
    .setEnable(setEnable), .strobes(strobes), .irqTake(irqTake),
    .irqVec(irqVec), .intEnable(intEnable)
  );
endmodule

// File: tb/sim_irq_ctrl.sv
module sim_irq_ctrl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, cycleEn, timerOvf, setEnable;
  logic [1:0] pinIn, clrMask;
  logic irqTake, irqVec, intEnable;
  logic [1:0] maskFlags, pinLevel;

  irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .cycleEn(cycleEn), .pinIn(pinIn),
    .timerOvf(timerOvf), .setEnable(setEnable), .clrMask(clrMask),
    .irqTake(irqTake), .irqVec(irqVec), .intEnable(intEnable),
    .maskFlags(maskFlags), .pinLevel(pinLevel)
  );

  int vectors = 0;
  int miscompares = 0;
  int takesSeen = 0;
  logic lastVec = 1'b0;
  bit done = 1'b0;

  // reference state, built from the requirements
  logic [1:0] mS1, mS2, mPrev, mMask;
  logic mIn, mTm, mEn, mTake, mVec;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [10:0] nextModel();
    logic [1:0] pulse, acc, s1, s2, pv, mk;
    logic takeI, takeT, en;
    pulse = {2{cycleEn}} & mS2 & ~mPrev;
    acc   = pulse & ~mMask;
    s1 = cycleEn ? pinIn : mS1;
    s2 = cycleEn ? mS1 : mS2;
    pv = cycleEn ? mS2 : mPrev;
    mk = (mMask & ~clrMask) | pulse;
    takeI = mEn & mIn;
    takeT = mEn & ~mIn & mTm;
    en = (takeI | takeT) ? 1'b0 : (mEn | setEnable);
    return {s1, s2, pv, mk, ((mIn & ~takeI) | (|acc)), ((mTm & ~takeT) | timerOvf), en};
  endfunction

  task automatic step();
    logic [10:0] n;
    logic nTake, nVec;
    n = nextModel();
    nTake = mEn & (mIn | mTm);
    nVec  = mEn & ~mIn & mTm;
    @(negedge clk);
    if (!rstN) begin
      {mS1, mS2, mPrev, mMask} = '0;
      {mIn, mTm, mEn, mTake, mVec} = '0;
    end else begin
      {mS1, mS2, mPrev, mMask, mIn, mTm, mEn} = n;
      mTake = nTake;
      mVec  = nVec;
    end
    check("R7 irqTake", irqTake, mTake);
    check("R9 irqVec", irqVec, mVec);
    check("R10 intEnable", intEnable, mEn);
    check("R4 maskFlags", maskFlags, mMask);
    check("R2 pinLevel", pinLevel, mS2);
    if (irqTake) begin
      takesSeen++;
      lastVec = irqVec;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulseSetEnable();
    setEnable = 1'b1; step(); setEnable = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; cycleEn = 1'b1; pinIn = '0; timerOvf = 1'b0;
    setEnable = 1'b0; clrMask = '0;
    run(3);
    // R1: reset state
    check("R1 take", irqTake, 0);
    check("R1 enable", intEnable, 0);
    check("R1 masks", maskFlags, 0);
    rstN = 1'b1;
    step();
    check("R1 levels", pinLevel, 0);

    // R2: level appears on second sampling edge
    pinIn = 2'b01; step();
    check("R2 first edge", pinLevel, 2'b00);
    step();
    check("R2 second edge", pinLevel, 2'b01);

    // R3, R4, R7: held-high pin gives a single input take
    takesSeen = 0;
    pulseSetEnable();
    run(20);
    check("R3 single pulse", takesSeen, 1);
    check("R7 vector input", lastVec, 0);
    check("R7 enable cleared", intEnable, 0);
    check("R4 mask set", maskFlags, 2'b01);

    // R4: masked pin re-pulse raises nothing
    pinIn = 2'b00; run(4); pinIn = 2'b01; run(4);
    takesSeen = 0;
    pulseSetEnable(); run(8);
    check("R4 masked ignored", takesSeen, 0);

    // R5: mask clear
    clrMask = 2'b01; step(); clrMask = 2'b00;
    check("R5 mask cleared", maskFlags, 2'b00);
    pinIn = 2'b00; run(4);

    // R8, R6: timer pending while disabled, then served
    setEnable = 1'b0;
    timerOvf = 1'b1; step(); timerOvf = 1'b0;
    takesSeen = 0;
    // intEnable is still 1 from above; drain via model anyway
    run(4);
    if (takesSeen == 0) begin
      pulseSetEnable(); run(3);
    end
    check("R6 timer served", takesSeen, 1);
    check("R6 timer vector", lastVec, 1);

    // R8, R9: both pending while disabled
    pinIn = 2'b10; timerOvf = 1'b1; step(); timerOvf = 1'b0;
    takesSeen = 0;
    run(10);
    check("R8 held while disabled", takesSeen, 0);
    pulseSetEnable(); run(3);
    check("R9 input first", takesSeen, 1);
    check("R9 input vector", lastVec, 0);
    run(5);
    check("R9 timer still waiting", takesSeen, 1);
    pulseSetEnable(); run(3);
    check("R9 timer second", takesSeen, 2);
    check("R9 timer vector", lastVec, 1);
    check("R10 enable cleared by take", intEnable, 0);

    // random phase with sparse cycle enables
    clrMask = 2'b11; step(); clrMask = 2'b00;
    for (int i = 0; i < 4000; i++) begin
      cycleEn   = ($urandom % 4) != 0;
      if (($urandom % 6) == 0) pinIn[0] = ~pinIn[0];
      if (($urandom % 6) == 0) pinIn[1] = ~pinIn[1];
      timerOvf  = ($urandom % 20) == 0;
      setEnable = ($urandom % 8) == 0;
      clrMask   = {($urandom % 12) == 0, ($urandom % 12) == 0};
      step();
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule